// File: doc/BRIEF.md
# Piezo printhead serial row loader

This block fills a piezo inkjet head with one row of print data each time the carriage advances by one encoder step. Every color channel has its own serial data line, and all lines share one head clock. A channel's row is 212 bits long. It starts with a 2-bit drop-size code for each of the 90 nozzles. A 32-bit waveform-select word follows, and the head uses it to map each code value to one of eight physical drive waveforms. That mapping applies to the whole row.

The head samples data on both the rising and the falling edge of its clock. A row therefore needs 106 clock periods. The clock half-period is a parameter counted in system clocks, so the row can be sized to fit inside one encoder interval. The data line only moves halfway between clock edges. After the last edge a latch-enable pulse of programmable width tells the head to take the new pattern. A position strobe that arrives while a row is still in flight is reported as an overrun and is otherwise ignored.

Top module: `piezo_row_loader`

## Requirements
- R1: After reset, head_clk_o, head_data_o, latch_o, busy_o, done_o and overrun_o are all low.
- R2: A step_i pulse while idle with enable_i high starts a load, and busy_o is high from the next cycle. With enable_i low the strobe is ignored: busy_o stays low and the head clock does not move.
- R3: Each color c emits 212 bits. Nozzle n's code comes from nozzle_codes_i[c*180+2n +: 2] and wave_sel_i supplies bits [c*32 +: 32]. The order is nozzle 0 up to nozzle 89, each code MSB first, and then the waveform word from bit 31 down to bit 0. All colors run on the same clock edges.
- R4: The head clock rests low and each load produces exactly 212 edges, counting both rising and falling edges, so it ends low. The first edge comes HALF_DIV system cycles after busy_o rises, and later edges are spaced HALF_DIV system cycles apart.
- R5: head_data_o never changes on a system cycle in which head_clk_o toggles. Each bit is stable for at least one system cycle before the head edge that samples it.
- R6: latch_o rises on the same system edge as the 212th head clock edge and stays high for LATCH_LEN system cycles. The head clock does not move while it is high.
- R7: busy_o falls on the same system edge as latch_o. done_o is high for exactly the one cycle following that edge.
- R8: A step_i pulse while busy_o is high makes overrun_o high for the next cycle only. The running load finishes with the data captured at its own start.
- R9: The nozzle and waveform inputs are captured on the starting strobe, and later changes do not alter the row in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows strobes to start loads |
| step_i | input | 1 | Position-advance strobe, one cycle |
| nozzle_codes_i | input | N_COLORS*NOZZLES*CODE_W | Drop-size codes, per color and nozzle |
| wave_sel_i | input | N_COLORS*WSEL_W | Waveform-select word per color |
| head_clk_o | output | 1 | Shared head shift clock |
| head_data_o | output | N_COLORS | Serial data, one line per color |
| latch_o | output | 1 | Latch-enable pulse to the head |
| busy_o | output | 1 | Load or latch in progress |
| done_o | output | 1 | One-cycle pulse when a load ends |
| overrun_o | output | 1 | One-cycle pulse for a strobe lost while busy |

## Verification
The bench records every head clock edge on both polarities and rebuilds each color's 212-bit stream from it. A swapped code bit order, a reversed nozzle order, or a waveform word shifted by one position shows up as a stream mismatch. The bench also counts edges, so one edge too many or too few, or a clock left high at the end, is caught. Each edge is checked against the time the data last moved, which exposes a design that shifts on the same cycle as the clock toggles. The latch and busy timing is checked against the last edge, so a latch that overlaps clocking or a busy flag that drops early is reported. A second strobe is issued mid-load while the inputs change, which catches designs that restart the load, recapture the inputs, or drop the overrun pulse.

// File: rtl/piezo_ld_pkg.sv
package piezo_ld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } ld_state_e;
endpackage

// File: rtl/piezo_ld_timer.sv
// Head clock divider and edge counter; data shift strobe sits mid half-period.
module piezo_ld_timer #(
  parameter int HALF_DIV    = 4,
  parameter int TOTAL_EDGES = 212
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic head_clk_o,
  output logic shift_o,
  output logic last_o
);
  localparam int DW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam int EW = $clog2(TOTAL_EDGES + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
  localparam logic [DW-1:0] DIV_MID  = DW'((HALF_DIV - 1) / 2);
  localparam logic [EW-1:0] EDGE_LAST = EW'(TOTAL_EDGES - 1);

  logic [DW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic          clk_q;
  logic          edge_hit;

  assign edge_hit   = run_i && (div_q == DIV_LAST);
  assign shift_o    = run_i && (div_q == DIV_MID) && (edge_q != '0);
  assign last_o     = edge_hit && (edge_q == EDGE_LAST);
  assign head_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      edge_q <= '0;
      clk_q  <= 1'b0;
    end else if (start_i) begin
      div_q  <= '0;
      edge_q <= '0;
      clk_q  <= 1'b0;
    end else if (run_i) begin
      if (edge_hit) begin
        div_q  <= '0;
        edge_q <= edge_q + 1'b1;
        clk_q  <= ~clk_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/piezo_ld_lane.sv
// One color: builds the row image and shifts it out MSB first.
module piezo_ld_lane #(
  parameter int NOZZLES = 90,
  parameter int CODE_W  = 2,
  parameter int WSEL_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      shift_i,
  input  logic [NOZZLES*CODE_W-1:0] codes_i,
  input  logic [WSEL_W-1:0]         wsel_i,
  output logic                      sdo_o
);
  localparam int TOTAL = NOZZLES * CODE_W + WSEL_W;

  logic [TOTAL-1:0] image;
  logic [TOTAL-1:0] sh_q;

  always_comb begin
    image = '0;
    for (int n = 0; n < NOZZLES; n++) begin
      image[TOTAL-1-CODE_W*n -: CODE_W] = codes_i[n*CODE_W +: CODE_W];
    end
    image[WSEL_W-1:0] = wsel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= image;
    else if (shift_i) sh_q <= {sh_q[TOTAL-2:0], 1'b0};
  end

  assign sdo_o = sh_q[TOTAL-1];
endmodule

// File: rtl/piezo_ld_ctrl.sv
// Load sequencer: idle -> shift -> latch -> idle.
module piezo_ld_ctrl
  import piezo_ld_pkg::*;
#(
  parameter int LATCH_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic step_i,
  input  logic last_edge_i,
  output logic load_o,
  output logic run_o,
  output logic latch_o,
  output logic busy_o,
  output logic done_o,
  output logic overrun_o
);
  localparam int LW = $clog2(LATCH_LEN) + 1;
  localparam logic [LW-1:0] LAT_LAST = LW'(LATCH_LEN - 1);

  ld_state_e     state_q;
  logic [LW-1:0] lat_q;
  logic          done_q;
  logic          ovr_q;

  assign busy_o    = (state_q != ST_IDLE);
  assign load_o    = (state_q == ST_IDLE) && step_i && enable_i;
  assign run_o     = (state_q == ST_SHIFT);
  assign latch_o   = (state_q == ST_LATCH);
  assign done_o    = done_q;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ovr_q  <= step_i && busy_o;
      unique case (state_q)
        ST_IDLE: if (load_o) state_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (last_edge_i) begin
            state_q <= ST_LATCH;
            lat_q   <= '0;
          end
        end
        ST_LATCH: begin
          if (lat_q == LAT_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            lat_q <= lat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/piezo_row_loader.sv
module piezo_row_loader #(
  parameter int N_COLORS  = 4,
  parameter int NOZZLES   = 90,
  parameter int CODE_W    = 2,
  parameter int WSEL_W    = 32,
  parameter int HALF_DIV  = 4,
  parameter int LATCH_LEN = 3
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               enable_i,
  input  logic                               step_i,
  input  logic [N_COLORS*NOZZLES*CODE_W-1:0] nozzle_codes_i,
  input  logic [N_COLORS*WSEL_W-1:0]         wave_sel_i,
  output logic                               head_clk_o,
  output logic [N_COLORS-1:0]                head_data_o,
  output logic                               latch_o,
  output logic                               busy_o,
  output logic                               done_o,
  output logic                               overrun_o
);
  localparam int ROW_BITS = NOZZLES * CODE_W;
  localparam int TOTAL    = ROW_BITS + WSEL_W;

  logic load, run, shift, last_edge, busy;
  logic [N_COLORS-1:0] sdo;

  piezo_ld_ctrl #(.LATCH_LEN(LATCH_LEN)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .step_i      (step_i),
    .last_edge_i (last_edge),
    .load_o      (load),
    .run_o       (run),
    .latch_o     (latch_o),
    .busy_o      (busy),
    .done_o      (done_o),
    .overrun_o   (overrun_o)
  );

  piezo_ld_timer #(.HALF_DIV(HALF_DIV), .TOTAL_EDGES(TOTAL)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (load),
    .run_i      (run),
    .head_clk_o (head_clk_o),
    .shift_o    (shift),
    .last_o     (last_edge)
  );

  for (genvar c = 0; c < N_COLORS; c++) begin : g_lane
    piezo_ld_lane #(.NOZZLES(NOZZLES), .CODE_W(CODE_W), .WSEL_W(WSEL_W)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (shift),
      .codes_i (nozzle_codes_i[c*ROW_BITS +: ROW_BITS]),
      .wsel_i  (wave_sel_i[c*WSEL_W +: WSEL_W]),
      .sdo_o   (sdo[c])
    );
    // data held quiet outside a load
    assign head_data_o[c] = sdo[c] & busy;
  end

  assign busy_o = busy;
endmodule

// File: rtl/piezo_ld_chk.sv
module piezo_ld_chk #(
  parameter int N_COLORS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic                step_i,
  input logic                head_clk_o,
  input logic [N_COLORS-1:0] head_data_o,
  input logic                latch_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                overrun_o
);
  // R2
  ignore_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && step_i && !enable_i) |=> !busy_o);
  // R4
  clk_rest_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !head_clk_o);
  // R5
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(head_clk_o) |-> $stable(head_data_o));
  // R6
  latch_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> (!head_clk_o && busy_o));
  // R7
  done_after_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(latch_o)));
  // R8
  overrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(step_i && busy_o));
endmodule

bind piezo_row_loader piezo_ld_chk #(.N_COLORS(N_COLORS)) i_piezo_ld_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .step_i      (step_i),
  .head_clk_o  (head_clk_o),
  .head_data_o (head_data_o),
  .latch_o     (latch_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .overrun_o   (overrun_o)
);

// File: tb/test_piezo_row_loader.sv
module test_piezo_row_loader;
  localparam int NC = 4, NZ = 90, CW = 2, WW = 32, HD = 4, LL = 3;
  localparam int TOT = NZ * CW + WW;
  localparam time CP = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, step = 1'b0;
  logic [NC*NZ*CW-1:0] nd = '0;
  logic [NC*WW-1:0]    ws = '0;
  logic head_clk, latch, busy, done, ovr;
  logic [NC-1:0] hdata;

  int total = 0, bad = 0;

  piezo_row_loader #(.N_COLORS(NC), .NOZZLES(NZ), .CODE_W(CW), .WSEL_W(WW),
                     .HALF_DIV(HD), .LATCH_LEN(LL)) i_piezo_row_loader (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .step_i(step),
    .nozzle_codes_i(nd), .wave_sel_i(ws), .head_clk_o(head_clk),
    .head_data_o(hdata), .latch_o(latch), .busy_o(busy), .done_o(done),
    .overrun_o(ovr));

  always #5 clk = ~clk;

  // monitors
  int n_edges = 0, setup_bad = 0;
  logic [TOT-1:0] cap [NC];
  time t_dchg = 0, t_prev = 0, t_first = 0, min_iv = 0, max_iv = 0;
  time t_lat_r = 0, t_lat_f = 0, t_busy_r = 0, t_busy_f = 0;

  always @(hdata) t_dchg = $time;
  always @(posedge head_clk or negedge head_clk) begin
    if (rst_n) begin
      if ($time - t_dchg < CP) setup_bad++;
      for (int c = 0; c < NC; c++)
        if (n_edges < TOT) cap[c][TOT-1-n_edges] = hdata[c];
      if (n_edges == 0) t_first = $time;
      else begin
        if (n_edges == 1 || $time - t_prev < min_iv) min_iv = $time - t_prev;
        if (n_edges == 1 || $time - t_prev > max_iv) max_iv = $time - t_prev;
      end
      t_prev = $time;
      n_edges++;
    end
  end
  always @(posedge latch) t_lat_r = $time;
  always @(negedge latch) t_lat_f = $time;
  always @(posedge busy)  t_busy_r = $time;
  always @(negedge busy)  t_busy_f = $time;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input int c, input logic [TOT-1:0] act,
                         input logic [TOT-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s color %0d: actual=%h expected=%h", req, c, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] exp_row(input int c, input logic [NC*NZ*CW-1:0] d,
                                             input logic [NC*WW-1:0] w);
    logic [TOT-1:0] v;
    for (int n = 0; n < NZ; n++) begin
      v[TOT-1-2*n] = d[c*NZ*CW + 2*n + 1];
      v[TOT-2-2*n] = d[c*NZ*CW + 2*n];
    end
    v[WW-1:0] = w[c*WW +: WW];
    return v;
  endfunction

  task automatic pulse_step();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
  endtask

  task automatic clear_mon();
    n_edges = 0; setup_bad = 0;
    for (int c = 0; c < NC; c++) cap[c] = '0;
  endtask

  // start a load, optionally disturb it mid-way, and check the whole row
  task automatic run_load(input string name, input bit disturb);
    logic [NC*NZ*CW-1:0] d0;
    logic [NC*WW-1:0] w0;
    int guard;
    bit seen;
    d0 = nd; w0 = ws;
    clear_mon();
    pulse_step();
    chk(busy === 1'b1, "R2 busy after strobe", busy, 1);
    if (disturb) begin
      repeat (60) @(negedge clk);
      nd = ~nd; ws = ~ws;
      step = 1'b1;
      @(negedge clk) step = 1'b0;
      chk(ovr === 1'b1, "R8 overrun pulse", ovr, 1);
      @(negedge clk);
      chk(ovr === 1'b0, "R8 overrun one cycle", ovr, 0);
      chk(busy === 1'b1, "R8 load continues", busy, 1);
    end
    seen = 0; guard = 0;
    while (!seen && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (done === 1'b1) seen = 1;
    end
    chk(seen, {"R7 done seen ", name}, seen, 1);
    chk(busy === 1'b0, "R7 busy low at done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", done, 0);
    chk(n_edges == TOT, {"R4 edge count ", name}, n_edges, TOT);
    chk(head_clk === 1'b0, "R4 clock ends low", head_clk, 0);
    chk(t_first - t_busy_r == HD*CP, "R4 first edge delay", t_first - t_busy_r, HD*CP);
    chk(min_iv == HD*CP && max_iv == HD*CP, "R4 half period", max_iv, HD*CP);
    chk(setup_bad == 0, "R5 data setup", setup_bad, 0);
    chk(t_lat_r == t_prev, "R6 latch at last edge", t_lat_r, t_prev);
    chk(t_lat_f - t_lat_r == LL*CP, "R6 latch width", t_lat_f - t_lat_r, LL*CP);
    chk(t_busy_f == t_lat_f, "R7 busy ends with latch", t_busy_f, t_lat_f);
    chk(hdata === '0, "R1 data idle low", hdata, 0);
    for (int c = 0; c < NC; c++)
      chk_vec(disturb ? "R9 R3 row captured at strobe" : {"R3 row ", name}, c, cap[c],
              exp_row(c, d0, w0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(head_clk === 1'b0 && latch === 1'b0, "R1 clk/latch reset", {head_clk, latch}, 0);
    chk(busy === 1'b0 && done === 1'b0 && ovr === 1'b0, "R1 flags reset", {busy, done, ovr}, 0);
    chk(hdata === '0, "R1 data reset", hdata, 0);
  endtask

  task automatic t_disabled();
    en = 1'b0;
    clear_mon();
    pulse_step();
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R2 ignored when disabled", busy, 0);
    chk(n_edges == 0, "R2 no clock when disabled", n_edges, 0);
    en = 1'b1;
  endtask

  task automatic t_patterns();
    for (int i = 0; i < NC*NZ*CW; i++) nd[i] = 1'($urandom);
    for (int i = 0; i < NC*WW; i++) ws[i] = 1'($urandom);
    run_load("random", 1'b0);
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < NZ; n++) nd[c*NZ*CW + 2*n +: 2] = 2'((n + c) % 4);
    for (int c = 0; c < NC; c++) ws[c*WW +: WW] = 32'h8000_0001 ^ (32'h11 << c);
    run_load("ramp", 1'b0);
    nd = '1; ws = '0;
    run_load("ones", 1'b0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < NC*NZ*CW; i++) nd[i] = 1'($urandom);
    for (int i = 0; i < NC*WW; i++) ws[i] = 1'($urandom);
    run_load("overrun", 1'b1);
  endtask

  initial begin
    #(2_000_000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    en = 1'b1;
    t_disabled();
    t_patterns();
    t_overrun();
    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule